// File: doc/BRIEF.md
# Width-Configurable Sample FIFO

This block holds converted analog samples between the conversion engine and a programmed-I/O read port. Each incoming sample carries a bipolar flag. At the moment it is written, the sample is widened to the storage format in force. In the 2-byte format an entry is 16 bits wide. In the 4-byte format it is 32 bits wide. A bipolar sample is widened with its sign bit and a unipolar sample with zeros. The format is chosen by a configuration bit, but that bit is only taken in when the FIFO is flushed. Software therefore cannot change the format while samples are stored in it.

The reader states the width of every read it makes. A read whose width differs from the stored format is refused. It returns zero, leaves the contents alone and raises a sticky illegal-access flag. The block reports how many entries it holds. It can also mark the end of an acquisition: when notification is enabled and the sample flagged as last is stored, a done flag rises and every later write is refused until the next flush. Writes into a full FIFO and reads from an empty one are dropped, and each raises its own sticky flag. When the sample resolution is above 16 bits, the 2-byte format cannot hold a sample, so the block always uses the 4-byte format.

Top module: `smp_fifo`

## Requirements
- R1: After the asynchronous reset, count_o is 0, done_o, illegal_o, overflow_o and underflow_o are 0, and rd_data_o is 0. The stored format is 2-byte, or 4-byte when RES_W exceeds 16.
- R2: cfg_wide_i is sampled only in a cycle where flush_i is 1 (0 selects 2-byte, 1 selects 4-byte). Changing it in any other cycle has no effect on the stored format or on which read width is legal.
- R3: In the 2-byte format, a legal read uses rd_wide_i = 0. rd_data_o[31:16] is 0, and rd_data_o[15:0] is the sample widened to 16 bits: with its sign bit when wr_bipolar_i was 1, with zeros otherwise.
- R4: In the 4-byte format, a legal read uses rd_wide_i = 1. rd_data_o is the sample widened to 32 bits: with its sign bit when wr_bipolar_i was 1, with zeros otherwise.
- R5: count_o gives the number of stored entries one cycle after the write or read that changed it. Entries are read back in write order. A legal read and a write may happen in the same cycle.
- R6: When cfg_notify_i is 1 and a write with wr_last_i = 1 is accepted, done_o is 1 from the next cycle on. While done_o is 1, writes are dropped without changing count_o or overflow_o. With cfg_notify_i = 0, wr_last_i has no effect.
- R7: A read whose rd_wide_i differs from the stored format returns rd_data_o = 0, leaves count_o unchanged and sets illegal_o, which stays 1 until a flush.
- R8: A write when count_o equals DEPTH is dropped, even if a read pops an entry in the same cycle, and it sets overflow_o until a flush.
- R9: A legal-width read when count_o is 0 returns rd_data_o = 0 and sets underflow_o until a flush.
- R10: flush_i empties the FIFO and clears done_o, all sticky flags and rd_data_o, and takes precedence over a read or write in the same cycle.
- R11: When RES_W exceeds 16, the 4-byte format is used whatever cfg_wide_i is at the flush, and a read with rd_wide_i = 0 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous FIFO reset; loads the storage format |
| cfg_wide_i | input | 1 | Requested format: 0 = 2-byte, 1 = 4-byte |
| cfg_notify_i | input | 1 | Enables the done notification |
| wr_en_i | input | 1 | Write a sample |
| wr_data_i | input | RES_W | Sample value |
| wr_bipolar_i | input | 1 | 1 = signed sample, 0 = unsigned |
| wr_last_i | input | 1 | Marks the final sample of an acquisition |
| rd_en_i | input | 1 | Read request |
| rd_wide_i | input | 1 | Read width: 0 = 16 bits, 1 = 32 bits |
| rd_data_o | output | 32 | Result of the last read request |
| count_o | output | CNT_W | Entries stored |
| done_o | output | 1 | Acquisition done; writes locked out |
| illegal_o | output | 1 | Sticky: a read of the wrong width was made |
| overflow_o | output | 1 | Sticky: a write to a full FIFO was dropped |
| underflow_o | output | 1 | Sticky: a read of an empty FIFO was made |

## Verification
The bench changes the width bit without a flush and then reads at the old width. A design that took the bit in directly would flag the read as illegal or would widen samples in the new format. Negative bipolar samples are read in both formats, so a design with the wrong extension rule shows up as wrong upper bits. The FIFO is filled to the top with a pop in the same cycle as an extra write, and it is read while empty with a write in the same cycle. Mistakes in the full or empty tests then show up in count_o, in the sticky flags or as a lost entry. Writes after the done flag, and flushes that coincide with reads and writes, catch a design that leaks entries past the lockout or lets the flush lose its priority.

// File: rtl/smpf_pkg.sv
package smpf_pkg;

  localparam int ENTRY_W = 32;
  localparam int HALF_W  = 16;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_POP   = 2'd1,
    RD_BADW  = 2'd2,
    RD_EMPTY = 2'd3
  } rd_kind_e;

  // Widen a raw sample of res_w bits to a storage entry.
  function automatic logic [ENTRY_W-1:0] widen_sample(
    input logic [ENTRY_W-1:0] raw,
    input int unsigned        res_w,
    input logic               bipolar,
    input logic               wide
  );
    logic [ENTRY_W-1:0] r;
    logic               fill;
    fill = bipolar & raw[res_w-1];
    for (int i = 0; i < ENTRY_W; i++) begin
      if (i < int'(res_w))          r[i] = raw[i];
      else if (!wide && i >= HALF_W) r[i] = 1'b0;
      else                           r[i] = fill;
    end
    return r;
  endfunction

endpackage

// File: rtl/smpf_fmt.sv
module smpf_fmt
  import smpf_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic [RES_W-1:0]   sample_i,
  input  logic               bipolar_i,
  input  logic               wide_i,
  output logic [ENTRY_W-1:0] entry_o
);

  localparam int PAD_W = ENTRY_W - RES_W;

  logic [ENTRY_W-1:0] raw;

  always_comb begin
    raw     = {{PAD_W{1'b0}}, sample_i};
    entry_o = widen_sample(raw, RES_W, bipolar_i, wide_i);
  end

endmodule

// File: rtl/smpf_store.sv
module smpf_store
  import smpf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  output logic [ENTRY_W-1:0] head_o,
  output logic [CNT_W-1:0]   count_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]      rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ptr_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_i) wr_ptr_d = step(wr_ptr_q);
      if (pop_i)  rd_ptr_d = step(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign ptr_en = flush_i | push_i | pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array carries no reset; pointers guard every read.
  always_ff @(posedge clk) begin
    if (push_i && !flush_i) mem[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/smpf_ctrl.sv
module smpf_ctrl
  import smpf_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 4,
  parameter bit FORCE_WIDE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               cfg_wide_i,
  input  logic               cfg_notify_i,
  input  logic               wr_en_i,
  input  logic               wr_last_i,
  input  logic               rd_en_i,
  input  logic               rd_wide_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [ENTRY_W-1:0] head_i,
  output logic               push_o,
  output logic               pop_o,
  output logic               mode_wide_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic               overflow_o,
  output logic               underflow_o,
  output logic [ENTRY_W-1:0] rd_data_o
);

  logic               mode_q, mode_d;
  logic               done_q, done_d;
  logic               ill_q, ill_d;
  logic               ovf_q, ovf_d;
  logic               unf_q, unf_d;
  logic [ENTRY_W-1:0] rd_q, rd_d;
  logic               full, empty, wr_open, rd_ld;
  rd_kind_e           rd_kind;

  assign full    = (count_i == CNT_W'(DEPTH));
  assign empty   = (count_i == '0);
  assign wr_open = wr_en_i & ~flush_i & ~done_q;
  assign push_o  = wr_open & ~full;

  always_comb begin
    if (!rd_en_i || flush_i)      rd_kind = RD_IDLE;
    else if (rd_wide_i != mode_q) rd_kind = RD_BADW;
    else if (empty)               rd_kind = RD_EMPTY;
    else                          rd_kind = RD_POP;
  end

  assign pop_o = (rd_kind == RD_POP);
  assign rd_ld = flush_i | rd_en_i;

  always_comb begin
    if (flush_i) begin
      mode_d = cfg_wide_i | FORCE_WIDE;
      done_d = 1'b0;
      ill_d  = 1'b0;
      ovf_d  = 1'b0;
      unf_d  = 1'b0;
      rd_d   = '0;
    end else begin
      mode_d = mode_q;
      done_d = done_q | (push_o & wr_last_i & cfg_notify_i);
      ill_d  = ill_q | (rd_kind == RD_BADW);
      ovf_d  = ovf_q | (wr_open & full);
      unf_d  = unf_q | (rd_kind == RD_EMPTY);
      rd_d   = (rd_kind == RD_POP) ? head_i : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FORCE_WIDE;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ld) rd_q <= rd_d;
  end

  assign mode_wide_o = mode_q;
  assign done_o      = done_q;
  assign illegal_o   = ill_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;
  assign rd_data_o   = rd_q;

endmodule

// File: rtl/smp_fifo.sv
module smp_fifo
  import smpf_pkg::*;
#(
  parameter  int RES_W = 14,
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               cfg_wide_i,
  input  logic               cfg_notify_i,
  input  logic               wr_en_i,
  input  logic [RES_W-1:0]   wr_data_i,
  input  logic               wr_bipolar_i,
  input  logic               wr_last_i,
  input  logic               rd_en_i,
  input  logic               rd_wide_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic               overflow_o,
  output logic               underflow_o
);

  localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit FORCE_WIDE = (RES_W > HALF_W);

  logic               mode_wide;
  logic               push, pop;
  logic [ENTRY_W-1:0] wentry, head;

  smpf_fmt #(.RES_W(RES_W)) u_fmt (
    .sample_i  (wr_data_i),
    .bipolar_i (wr_bipolar_i),
    .wide_i    (mode_wide),
    .entry_o   (wentry)
  );

  smpf_store #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wentry),
    .head_o  (head),
    .count_o (count_o)
  );

  smpf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FORCE_WIDE(FORCE_WIDE)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .cfg_wide_i   (cfg_wide_i),
    .cfg_notify_i (cfg_notify_i),
    .wr_en_i      (wr_en_i),
    .wr_last_i    (wr_last_i),
    .rd_en_i      (rd_en_i),
    .rd_wide_i    (rd_wide_i),
    .count_i      (count_o),
    .head_i       (head),
    .push_o       (push),
    .pop_o        (pop),
    .mode_wide_o  (mode_wide),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o),
    .rd_data_o    (rd_data_o)
  );

endmodule

// File: rtl/smpf_chk.sv
module smpf_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              rd_wide_i,
  input logic              mode_wide,
  input logic [31:0]       rd_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              overflow_o,
  input logic              underflow_o
);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> mode_wide == $past(mode_wide));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wide |-> rd_data_o[31:16] == 16'h0000);

  p_done_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wr_en_i && !rd_en_i && !flush_i) |=> count_o == $past(count_o));

  p_illegal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && !flush_i) |=> illegal_o);

  p_badwidth_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && !flush_i && rd_wide_i != mode_wide)
      |=> (count_o == $past(count_o)) && illegal_o && rd_data_o == 32'h0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_W'(DEPTH) && wr_en_i && !done_o && !flush_i) |=> overflow_o);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && rd_en_i && rd_wide_i == mode_wide && !flush_i)
      |=> underflow_o && rd_data_o == 32'h0);

  p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> count_o == '0 && !done_o && !illegal_o && !overflow_o && !underflow_o);

endmodule

bind smp_fifo smpf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_smpf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .rd_wide_i   (rd_wide_i),
  .mode_wide   (mode_wide),
  .rd_data_o   (rd_data_o),
  .count_o     (count_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/test_smp_fifo.sv
`timescale 1ns/1ps
module test_smp_fifo;

  localparam int RW = 14;
  localparam int DP = 8;
  localparam int CW = $clog2(DP + 1);

  logic clk, rst_n;
  logic flush, cwide, notify, we, bip, last, re, rwide;
  logic [RW-1:0] wd;
  logic [31:0]   rd;
  logic [CW-1:0] cnt;
  logic done, ill, ovf, unf;

  // second instance: resolution above 16 bits
  logic w_flush, w_cwide, w_we, w_bip, w_re, w_rwide;
  logic [19:0] w_wd;
  logic [31:0] w_rd;
  logic [2:0]  w_cnt;
  logic w_done, w_ill, w_ovf, w_unf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] q[$];
  bit e_mode, e_done, e_ill, e_ovf, e_unf, was_flush;
  logic [31:0] e_rd;

  smp_fifo #(.RES_W(RW), .DEPTH(DP)) i_smp_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .cfg_wide_i(cwide),
    .cfg_notify_i(notify), .wr_en_i(we), .wr_data_i(wd), .wr_bipolar_i(bip),
    .wr_last_i(last), .rd_en_i(re), .rd_wide_i(rwide), .rd_data_o(rd),
    .count_o(cnt), .done_o(done), .illegal_o(ill), .overflow_o(ovf),
    .underflow_o(unf));

  smp_fifo #(.RES_W(20), .DEPTH(4)) i_smp_fifo_w (
    .clk(clk), .rst_n(rst_n), .flush_i(w_flush), .cfg_wide_i(w_cwide),
    .cfg_notify_i(1'b0), .wr_en_i(w_we), .wr_data_i(w_wd), .wr_bipolar_i(w_bip),
    .wr_last_i(1'b0), .rd_en_i(w_re), .rd_wide_i(w_rwide), .rd_data_o(w_rd),
    .count_o(w_cnt), .done_o(w_done), .illegal_o(w_ill), .overflow_o(w_ovf),
    .underflow_o(w_unf));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_entry(input logic [RW-1:0] d, input bit b, input bit wide);
    logic [31:0] v;
    v = b ? 32'($signed(d)) : 32'(d);
    if (!wide) v[31:16] = 16'h0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    string t;
    t = was_flush ? "R10" : "R5";
    chk(cnt == CW'(q.size()), t, "count", 32'(cnt), 32'(q.size()));
    chk(done == e_done, was_flush ? "R10" : "R6", "done", 32'(done), 32'(e_done));
    chk(ill == e_ill, was_flush ? "R10" : "R7", "illegal", 32'(ill), 32'(e_ill));
    chk(ovf == e_ovf, was_flush ? "R10" : "R8", "overflow", 32'(ovf), 32'(e_ovf));
    chk(unf == e_unf, was_flush ? "R10" : "R9", "underflow", 32'(unf), 32'(e_unf));
    chk(rd == e_rd, e_mode ? "R4" : "R3", "read data", rd, e_rd);
  endtask

  // One cycle: drive at the falling edge, model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(input bit fl, input bit cw, input bit nt, input bit w,
                     input logic [RW-1:0] d, input bit b, input bit ls,
                     input bit r, input bit rw);
    bit full_pre, empty_pre;
    flush = fl; cwide = cw; notify = nt; we = w; wd = d; bip = b;
    last = ls; re = r; rwide = rw;
    @(posedge clk);
    was_flush = fl;
    if (fl) begin
      q.delete();
      e_mode = cw; e_done = 0; e_ill = 0; e_ovf = 0; e_unf = 0; e_rd = '0;
    end else begin
      full_pre  = (q.size() == DP);
      empty_pre = (q.size() == 0);
      if (r) begin
        if (rw != e_mode) begin e_ill = 1; e_rd = '0; end
        else if (empty_pre) begin e_unf = 1; e_rd = '0; end
        else e_rd = q.pop_front();
      end
      if (w && !e_done) begin
        if (full_pre) e_ovf = 1;
        else begin
          q.push_back(exp_entry(d, b, e_mode));
          if (ls && nt) e_done = 1;
        end
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cyc(0, cwide, 0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    flush = 0; cwide = 0; notify = 0; we = 0; wd = '0; bip = 0; last = 0;
    re = 0; rwide = 0;
    w_flush = 0; w_cwide = 0; w_we = 0; w_wd = '0; w_bip = 0; w_re = 0; w_rwide = 0;
    e_mode = 0; e_done = 0; e_ill = 0; e_ovf = 0; e_unf = 0; e_rd = '0; was_flush = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cnt == '0 && !done && !ill && !ovf && !unf, "R1", "flags/count",
        {cnt, done, ill, ovf, unf}, '0);
    chk(rd == '0, "R1", "read data", rd, '0);
    rst_n = 1;
    @(negedge clk);
    // R1: default 2-byte format, empty narrow read is underflow not illegal
    cyc(0, 0, 0, 0, '0, 0, 0, 1, 0);
    chk(!ill && unf, "R1", "default narrow format", {ill, unf}, 32'b01);
    cyc(1, 0, 0, 0, '0, 0, 0, 0, 0);

    // R3: narrow entries, negative bipolar and unipolar
    cyc(0, 0, 0, 1, 14'h2001, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 14'h3FFF, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, '0, 0, 0, 1, 0);
    chk(rd == 32'h0000E001, "R3", "sign to 16", rd, 32'h0000E001);
    cyc(0, 0, 0, 0, '0, 0, 0, 1, 0);

    // R2: width bit changes without flush: no effect
    cyc(0, 1, 0, 1, 14'h2ABC, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, '0, 0, 0, 1, 0);
    chk(rd == 32'h0000EABC && !ill, "R2", "format kept", rd, 32'h0000EABC);
    cyc(1, 1, 0, 0, '0, 0, 0, 0, 0);

    // R4: wide entries
    cyc(0, 1, 0, 1, 14'h2001, 1, 0, 0, 1);
    cyc(0, 1, 0, 1, 14'h2001, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, '0, 0, 0, 1, 1);
    chk(rd == 32'hFFFFE001, "R4", "sign to 32", rd, 32'hFFFFE001);
    // R7: wrong-width read
    cyc(0, 1, 0, 0, '0, 0, 0, 1, 0);
    chk(rd == '0 && ill && cnt == 1, "R7", "bad width", rd, '0);
    cyc(0, 1, 0, 0, '0, 0, 0, 1, 1);
    chk(rd == 32'h00002001, "R4", "zero to 32", rd, 32'h00002001);

    // R8: fill, then write with a same-cycle pop
    for (int i = 0; i < DP; i++) cyc(0, 1, 0, 1, RW'(i + 5), 0, 0, 0, 1);
    cyc(0, 1, 0, 1, 14'h1111, 0, 0, 1, 1);
    chk(ovf && cnt == CW'(DP - 1), "R8", "full write dropped", {ovf, cnt}, {1'b1, CW'(DP - 1)});
    // R9: drain and read empty with a same-cycle write
    while (q.size() > 0) cyc(0, 1, 0, 0, '0, 0, 0, 1, 1);
    cyc(0, 1, 0, 1, 14'h0042, 0, 0, 1, 1);
    chk(unf && cnt == 1, "R9", "empty read", {unf, cnt}, {1'b1, CW'(1)});

    // R6: done notification and lockout
    cyc(1, 1, 1, 0, '0, 0, 0, 0, 1);
    cyc(0, 1, 0, 1, 14'h0010, 0, 1, 0, 1);
    chk(!done, "R6", "last without notify", 32'(done), 0);
    cyc(0, 1, 1, 1, 14'h0011, 0, 1, 0, 1);
    chk(done, "R6", "done raised", 32'(done), 1);
    cyc(0, 1, 1, 1, 14'h0012, 0, 0, 0, 1);
    chk(cnt == 2 && !ovf, "R6", "write locked", 32'(cnt), 2);
    // R10: flush beats same-cycle write and read
    cyc(1, 0, 0, 1, 14'h0013, 0, 0, 1, 1);
    chk(cnt == 0 && !done && rd == '0, "R10", "flush priority", 32'(cnt), 0);

    // random phase
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
    end
    for (int n = 0; n < 3000; n++) begin
      bit fl, cw, nt, w, r, rw, b, ls;
      fl = ($urandom_range(0, 47) == 0);
      cw = ($urandom_range(0, 1) == 1);
      nt = ($urandom_range(0, 3) == 0);
      ls = ($urandom_range(0, 15) == 0);
      w  = ($urandom_range(0, 2) != 0);
      r  = ($urandom_range(0, 2) != 0);
      b  = ($urandom_range(0, 1) == 1);
      rw = ($urandom_range(0, 9) == 0) ? !e_mode : e_mode;
      cyc(fl, cw, nt, w, RW'($urandom), b, ls, r, rw);
    end
    idle();

    // R11: resolution above 16 bits forces the 4-byte format
    @(negedge clk); w_flush = 1; w_cwide = 0;
    @(negedge clk); w_flush = 0; w_we = 1; w_wd = 20'h80001; w_bip = 1;
    @(negedge clk); w_we = 0; w_re = 1; w_rwide = 1;
    @(negedge clk); w_re = 0;
    chk(w_rd == 32'hFFF80001 && !w_ill, "R11", "forced wide read", w_rd, 32'hFFF80001);
    w_re = 1; w_rwide = 0;
    @(negedge clk); w_re = 0;
    chk(w_ill && w_rd == '0, "R11", "narrow read illegal", 32'(w_ill), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule